// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Strobe Divider

This block derives the serial audio timing for a converter link from one master audio clock. When it owns the link, one programmable divisor turns the master clock into a bit clock. Two further divisors, one for the transmit direction and one for the receive direction, count bit-clock periods to form two independent word-select strobes. A one-cycle enable marks the last master cycle of every bit period, so that shift registers elsewhere in the same clock domain can advance without a derived clock.

When a neighbour owns the link, the block stands aside. It forwards the external bit clock and both external word-select lines unchanged, and its own counters stay parked. All three divisor fields are written as the wanted count minus one. A field that changes while a period is running is picked up only where that period ends, so a reprogram never produces a short pulse.

Top module: `audio_clk_chain`

## Requirements
- R1: While `rst_n` is low in master mode, `bclk_en`, `bclk`, `tx_ws` and `rx_ws` are all 0.
- R2: With `mclk_div_m1` = N-1 and N of at least 2, `bclk` repeats every N master cycles. It is high for floor(N/2) cycles and then low for the remaining N - floor(N/2) cycles, so an odd N has a high phase one cycle shorter than the low phase.
- R3: With `mclk_div_m1` = 0 (divide by one), `bclk` follows `mclk` itself and `bclk_en` is high in every master cycle.
- R4: `bclk_en` is high for exactly one master cycle per bit period: the last cycle before `bclk` starts a new high phase.
- R5: With `tx_len_m1` = L-1 (and likewise `rx_len_m1` for `rx_ws`), the strobe repeats every L bit periods. It is low for floor(L/2) bit periods and then high for the rest. The two strobes use their own fields independently.
- R6: A word-select strobe changes only on the master edge that follows a `bclk_en` cycle, that is, at the start of a bit period.
- R7: A new value on any divisor field has no effect on the period in progress. The bit-clock field is taken at the end of a bit period, and a frame field at the end of that strobe's frame.
- R8: With `slave_i` = 1, `bclk`, `tx_ws` and `rx_ws` equal `ext_bclk`, `ext_tx_ws` and `ext_rx_ws`, `bclk_en` stays 0, and the divisor fields have no effect.
- R9: On the first master edge after `slave_i` returns to 0, the bit period and both frames restart from their first cycle. They use the field values present at that edge, so `bclk` is high and both strobes are low, and the first `bclk_en` follows N-1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_i | input | 1 | 1 = external timing is forwarded; 0 = this block drives the link |
| mclk_div_m1 | input | 8 | Bit-clock divide ratio minus one |
| rx_len_m1 | input | 8 | Receive frame length in bit periods, minus one |
| tx_len_m1 | input | 8 | Transmit frame length in bit periods, minus one |
| ext_bclk | input | 1 | Bit clock from the link owner, used in slave mode |
| ext_tx_ws | input | 1 | Transmit word select from the link owner, used in slave mode |
| ext_rx_ws | input | 1 | Receive word select from the link owner, used in slave mode |
| bclk_en | output | 1 | One-cycle enable in the last master cycle of each bit period |
| bclk | output | 1 | Bit-clock level |
| tx_ws | output | 1 | Transmit word-select strobe |
| rx_ws | output | 1 | Receive word-select strobe |

## Verification
The bench aims at the edges of the divisor range and at reprogramming. It covers an odd ratio, where a divider that rounds the wrong way would give the high phase the longer half, and the largest ratio of 256, where a narrow counter would wrap early. It also covers divide by one, where a registered divider would stall or halve the rate instead of forwarding the master clock. Divisors and frame lengths are changed in the middle of a period: a design that loads them at once would cut that period short. The bench then leaves slave mode with a ratio of 3, where stale counter state would shift the first enable or start a strobe at the wrong level.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // Who owns the bit clock and the frame strobes.
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;

  // A field holds count-1; the actual count is one more.
  function automatic int unsigned ratio_of(input int unsigned field_m1);
    return field_m1 + 32'd1;
  endfunction

  // True while position pos lies in the leading floor(len/2) slots of a period.
  function automatic logic in_lead_half(input int unsigned pos, input int unsigned len);
    return pos < (len >> 1);
  endfunction

endpackage

// File: rtl/aclk_bit_div.sv
module aclk_bit_div
  import aclk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] div_m1_i,
  output logic         tick_o,
  output logic         lvl_o,
  output logic         pass_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] ratio_q;
  logic         lvl_q;

  // Named internal events, also used by the assertions below.
  logic         at_end_w;
  logic [W-1:0] cnt_inc_w;

  assign at_end_w  = run_i && (cnt_q == ratio_q);
  assign cnt_inc_w = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      lvl_q   <= 1'b0;
    end else if (!run_i || at_end_w) begin
      // The ratio is sampled only here, at a period boundary or while parked.
      cnt_q   <= '0;
      ratio_q <= div_m1_i;
      lvl_q   <= in_lead_half(32'd0, ratio_of(32'(div_m1_i)));
    end else begin
      cnt_q   <= cnt_inc_w;
      lvl_q   <= in_lead_half(32'(cnt_inc_w), ratio_of(32'(ratio_q)));
    end
  end

  assign tick_o = at_end_w;
  assign lvl_o  = lvl_q;
  assign pass_o = (ratio_q == '0);

  AST_BCLK_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && $rose(lvl_q)) |-> $past(at_end_w)); // R2

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && at_end_w && $past(at_end_w)) |-> (ratio_q == '0)); // R4

  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !$past(at_end_w)) |-> $stable(ratio_q)); // R7

endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div
  import aclk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] len_m1_i,
  output logic         ws_o
);

  logic [W-1:0] pos_q;
  logic [W-1:0] len_q;
  logic         ws_q;

  logic         frame_end_w;
  logic [W-1:0] pos_inc_w;

  assign frame_end_w = run_i && tick_i && (pos_q == len_q);
  assign pos_inc_w   = pos_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= '0;
      ws_q  <= 1'b0;
    end else if (!run_i || frame_end_w) begin
      pos_q <= '0;
      len_q <= len_m1_i;
      ws_q  <= !in_lead_half(32'd0, ratio_of(32'(len_m1_i)));
    end else if (tick_i) begin
      pos_q <= pos_inc_w;
      ws_q  <= !in_lead_half(32'(pos_inc_w), ratio_of(32'(len_q)));
    end
  end

  assign ws_o = ws_q;

  AST_WS_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !$stable(ws_q)) |-> $past(tick_i)); // R6

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !$past(frame_end_w)) |-> $stable(len_q)); // R7

endmodule

// File: rtl/audio_clk_chain.sv
module audio_clk_chain
  import aclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             slave_i,
  input  logic [DIV_W-1:0] mclk_div_m1,
  input  logic [DIV_W-1:0] rx_len_m1,
  input  logic [DIV_W-1:0] tx_len_m1,
  input  logic             ext_bclk,
  input  logic             ext_tx_ws,
  input  logic             ext_rx_ws,
  output logic             bclk_en,
  output logic             bclk,
  output logic             tx_ws,
  output logic             rx_ws
);

  localparam int NUM_FRAMES = 2;  // index 0 = transmit, 1 = receive

  role_e role_w;
  logic  run_q;
  logic  tick_w;
  logic  lvl_w;
  logic  pass_w;

  logic [DIV_W-1:0]      len_sel_w [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] ws_div_w;
  logic [NUM_FRAMES-1:0] ws_ext_w;

  assign role_w = slave_i ? ROLE_SLAVE : ROLE_MASTER;

  // Counters run one edge after master mode is seen; the parked edge reloads them.
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= (role_w == ROLE_MASTER);
  end

  aclk_bit_div #(.W(DIV_W)) u_bit (
    .clk      (mclk),
    .rst_n    (rst_n),
    .run_i    (run_q),
    .div_m1_i (mclk_div_m1),
    .tick_o   (tick_w),
    .lvl_o    (lvl_w),
    .pass_o   (pass_w)
  );

  assign len_sel_w[0] = tx_len_m1;
  assign len_sel_w[1] = rx_len_m1;
  assign ws_ext_w     = {ext_rx_ws, ext_tx_ws};

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    aclk_frame_div #(.W(DIV_W)) u_frame (
      .clk      (mclk),
      .rst_n    (rst_n),
      .run_i    (run_q),
      .tick_i   (tick_w),
      .len_m1_i (len_sel_w[g]),
      .ws_o     (ws_div_w[g])
    );
  end

  always_comb begin
    if (role_w == ROLE_SLAVE) begin
      bclk_en = 1'b0;
      bclk    = ext_bclk;
      tx_ws   = ws_ext_w[0];
      rx_ws   = ws_ext_w[1];
    end else begin
      bclk_en = tick_w;
      bclk    = (run_q && pass_w) ? mclk : lvl_w;
      tx_ws   = ws_div_w[0];
      rx_ws   = ws_div_w[1];
    end
  end

  AST_SLAVE_PARKED: assert property (@(posedge mclk) disable iff (!rst_n)
    (slave_i && $past(slave_i)) |-> !tick_w); // R8

endmodule

// File: tb/tb_audio_clk_chain.sv
`timescale 1ns/1ps
module tb_audio_clk_chain;

  localparam int W = 8;

  logic         mclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         slave_i = 1'b0;
  logic [W-1:0] mdiv = 8'd3;
  logic [W-1:0] rxl  = 8'd4;
  logic [W-1:0] txl  = 8'd7;
  logic         ext_bclk = 1'b0;
  logic         ext_tx = 1'b0;
  logic         ext_rx = 1'b0;
  logic         bclk_en, bclk, tx_ws, rx_ws;

  audio_clk_chain #(.DIV_W(W)) dut (
    .mclk(mclk), .rst_n(rst_n), .slave_i(slave_i),
    .mclk_div_m1(mdiv), .rx_len_m1(rxl), .tx_len_m1(txl),
    .ext_bclk(ext_bclk), .ext_tx_ws(ext_tx), .ext_rx_ws(ext_rx),
    .bclk_en(bclk_en), .bclk(bclk), .tx_ws(tx_ws), .rx_ws(rx_ws)
  );

  always #2.5 mclk = ~mclk;

  typedef struct { int lead; int trail; } span_t;
  span_t bq[$];
  span_t tq[$];
  span_t rq[$];

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // ---------------- driver side: expected spans ----------------
  task automatic push_bit(input int n, input int times);
    span_t s;
    for (int i = 0; i < times; i++) begin
      s.lead = n / 2; s.trail = n - n / 2;
      bq.push_back(s);
    end
  endtask

  task automatic push_frame(input int ch, input int l, input int times);
    span_t s;
    for (int i = 0; i < times; i++) begin
      s.lead = l / 2; s.trail = l - l / 2;
      if (ch == 0) tq.push_back(s); else rq.push_back(s);
    end
  endtask

  // Change the bit divisor a cycle into a fresh period (R7).
  task automatic retime_bit(input int nv, input int n_new, input bit push_old);
    int oldn;
    oldn = int'(mdiv) + 1;
    while (bq.size() != 0) @(negedge mclk);
    @(negedge mclk);
    while (bclk_en !== 1'b1) @(negedge mclk);
    @(negedge mclk);
    if (push_old) push_bit(oldn, 1);
    mdiv = 8'(nv);
    push_bit(nv + 1, n_new);
  endtask

  // Change the transmit frame length just after a frame starts (R7).
  task automatic retime_tx(input int nv, input int n_new);
    int   oldl;
    logic p;
    oldl = int'(txl) + 1;
    while (tq.size() != 0) @(negedge mclk);
    p = tx_ws;
    @(negedge mclk);
    while (!(p == 1'b1 && tx_ws == 1'b0)) begin
      p = tx_ws;
      @(negedge mclk);
    end
    push_frame(0, oldl, 1);
    txl = 8'(nv);
    push_frame(0, nv + 1, n_new);
  endtask

  // ---------------- monitor side ----------------
  bit   b_arm = 0;
  logic b_prev = 0;
  int   b_hi = 0, b_lo = 0;
  bit   f_arm [2];
  logic f_prev [2];
  int   f_lo [2];
  int   f_hi [2];
  logic prev_en = 0, prev_slave = 0, prev_rstn = 0;

  task automatic mon_step();
    span_t e;
    logic  ws;
    bit    has;
    if (!rst_n) begin
      b_arm = 0; b_prev = 0; b_hi = 0; b_lo = 0;
      for (int c = 0; c < 2; c++) begin
        f_arm[c] = 1; f_prev[c] = 0; f_lo[c] = 0; f_hi[c] = 0;
      end
    end else if (slave_i) begin
      b_arm = 0; b_prev = bclk; b_hi = 0; b_lo = 0;
      f_arm[0] = 0; f_prev[0] = tx_ws; f_lo[0] = 0; f_hi[0] = 0;
      f_arm[1] = 0; f_prev[1] = rx_ws; f_lo[1] = 0; f_hi[1] = 0;
    end else begin
      // bit-clock periods, closed at each rise (R2)
      if (bclk && !b_prev) begin
        if (b_arm && bq.size() > 0) begin
          e = bq.pop_front();
          check(b_hi == e.lead && b_lo == e.trail, "R2", "bclk high*1000+low",
                b_hi * 1000 + b_lo, e.lead * 1000 + e.trail);
        end
        b_arm = 1; b_hi = 1; b_lo = 0;
      end else if (bclk) b_hi++;
      else b_lo++;
      b_prev = bclk;
      // frame strobes, closed at each fall (R5), moves only after an enable (R6)
      for (int c = 0; c < 2; c++) begin
        ws = (c == 0) ? tx_ws : rx_ws;
        if (prev_rstn && !prev_slave && ws != f_prev[c])
          check(prev_en == 1'b1, "R6", "ws moved without preceding bclk_en", 0, 1);
        if (!ws && f_prev[c]) begin
          has = 0;
          if (c == 0 && tq.size() > 0) begin e = tq.pop_front(); has = 1; end
          if (c == 1 && rq.size() > 0) begin e = rq.pop_front(); has = 1; end
          if (f_arm[c] && has)
            check(f_lo[c] == e.lead && f_hi[c] == e.trail, "R5",
                  (c == 0) ? "tx_ws low*1000+high" : "rx_ws low*1000+high",
                  f_lo[c] * 1000 + f_hi[c], e.lead * 1000 + e.trail);
          f_arm[c] = 1; f_lo[c] = 0; f_hi[c] = 0;
        end
        if (bclk_en) begin
          if (ws) f_hi[c]++; else f_lo[c]++;
        end
        f_prev[c] = ws;
      end
    end
    prev_en = bclk_en; prev_slave = slave_i; prev_rstn = rst_n;
  endtask

  always @(posedge mclk) begin
    #1;
    mon_step();
  end

  // watchdog
  int wd = 0;
  always @(posedge mclk) begin
    wd++;
    if (wd == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 0);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int cnt;
    int pairs;
    logic last;
    push_bit(4, 4);
    push_frame(0, 8, 2);
    push_frame(1, 5, 3);
    repeat (3) @(negedge mclk);
    check({bclk_en, bclk, tx_ws, rx_ws} == 4'b0, "R1", "outputs in reset",
          int'({bclk_en, bclk, tx_ws, rx_ws}), 0);
    rst_n = 1'b1;

    // R4: one enable per 4 master cycles, never back to back
    repeat (8) @(negedge mclk);
    cnt = 0; pairs = 0; last = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge mclk);
      if (bclk_en) cnt++;
      if (bclk_en && last) pairs++;
      last = bclk_en;
    end
    check(cnt == 10, "R4", "enables in 40 cycles at ratio 4", cnt, 10);
    check(pairs == 0, "R4", "back-to-back enables at ratio 4", pairs, 0);
    repeat (120) @(negedge mclk);
    check(tq.size() == 0 && rq.size() == 0, "R5", "frame spans left",
          tq.size() + rq.size(), 0);

    // odd ratio, then the largest ratio, then ratio 2 (R2, R7)
    retime_bit(4, 3, 1);
    retime_bit(255, 1, 1);
    retime_bit(1, 2, 1);
    // transmit frame reprogrammed mid-frame (R5, R7)
    retime_tx(63, 1);
    while (tq.size() != 0) @(negedge mclk);

    // divide by one (R3)
    retime_bit(0, 0, 1);
    repeat (6) @(negedge mclk);
    for (int i = 0; i < 2; i++) begin
      @(posedge mclk); #1;
      check(bclk == 1'b1 && bclk_en == 1'b1, "R3", "bclk/en while mclk high",
            int'({bclk, bclk_en}), 3);
      @(negedge mclk); #1;
      check(bclk == 1'b0 && bclk_en == 1'b1, "R3", "bclk/en while mclk low",
            int'({bclk, bclk_en}), 1);
    end
    // odd frame length at one master cycle per bit (R5)
    retime_tx(2, 3);
    while (tq.size() != 0 || bq.size() != 0) @(negedge mclk);

    // slave mode: forwarded lines, fields ignored (R8)
    @(negedge mclk);
    slave_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge mclk);
      ext_bclk = i[0]; ext_tx = i[1]; ext_rx = ~i[0];
      mdiv = 8'(i * 37); txl = 8'(i * 11); rxl = 8'(200 - i);
      @(posedge mclk); #1;
      check({bclk_en, bclk, tx_ws, rx_ws} == {1'b0, ext_bclk, ext_tx, ext_rx},
            "R8", "en,bclk,tx,rx in slave mode",
            int'({bclk_en, bclk, tx_ws, rx_ws}), int'({1'b0, ext_bclk, ext_tx, ext_rx}));
    end

    // leave slave mode: ratio 3, transmit length 2 (R9)
    @(negedge mclk);
    ext_bclk = 0; ext_tx = 0; ext_rx = 0;
    mdiv = 8'd2; txl = 8'd1; rxl = 8'd4;
    @(negedge mclk);
    slave_i = 1'b0;
    push_bit(3, 3);
    @(posedge mclk); #1;
    check(bclk == 1'b1 && bclk_en == 1'b0 && tx_ws == 1'b0 && rx_ws == 1'b0, "R9",
          "bclk,en,tx,rx on restart edge", int'({bclk, bclk_en, tx_ws, rx_ws}), 8);
    @(posedge mclk); #1;
    check(bclk == 1'b0 && bclk_en == 1'b0, "R9", "bclk,en one cycle later",
          int'({bclk, bclk_en}), 0);
    @(posedge mclk); #1;
    check(bclk_en == 1'b1, "R9", "first enable after restart", int'(bclk_en), 1);
    @(posedge mclk); #1;
    check(tx_ws == 1'b1 && bclk == 1'b1, "R9", "tx_ws,bclk after first bit",
          int'({tx_ws, bclk}), 3);
    while (bq.size() != 0) @(negedge mclk);
    repeat (4) @(negedge mclk);
    check(bq.size() == 0, "R2", "bit spans left", bq.size(), 0);
    finish_run();
  end

endmodule